// File: doc/BRIEF.md
# Quad Double-Buffered Serial Register Loader

This block is the digital front end of a four-channel converter that is loaded over a three-wire serial link. Each ten-bit frame carries a two-bit channel address followed by an eight-bit value. The bits enter a shift register on each falling edge of the serial clock. While the write strobe is low, the low eight bits of the shift register are copied into the input register that the address names.

The four input registers form the first stage. Software can stage new values in all four channels and leave the outputs unchanged. While the update strobe is low, the output registers take all four input registers on the same cycle. The oldest bit of the shift register is driven on a serial output pin, so several of these blocks can be chained. All four serial-side inputs pass through a two-flop synchronizer to a fast system clock, and edges are found on the synchronized values.

Top module: `quad_dac_loader`

## Requirements
- R1: Every falling edge of `ser_clk` shifts `ser_in` into a 10-bit shift register. The first bit is the address MSB, the second bit is the address LSB, and the next eight bits are the data from bit 7 down to bit 0.
- R2: Address value k (00, 01, 10, 11) selects channel k. The output register of channel k appears on `dac_q[8k+7:8k]`.
- R3: While `wr_n` is low, the data byte goes into the addressed input register. The other three input registers keep their values.
- R4: While `upd_n` is high, `dac_q` does not change, whatever is written to the input registers.
- R5: While `upd_n` is low, all four output registers copy their input registers on the same clock cycle.
- R6: A rising edge of `ser_clk` does not shift, and neither does any change of `ser_in` while `ser_clk` is high.
- R7: `ser_out` shows the oldest bit in the shift register. After a full frame it shows the address MSB. After each later falling edge it shows the next bit of that frame.
- R8: When `wr_n` and `upd_n` are low together, the addressed input register is written first. The output register shows the new value one cycle later and keeps it while both strobes stay low.
- R9: Reset clears the shift register, all input registers, all output registers and `ser_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial address and data input |
| ser_clk | input | 1 | Serial clock; a bit is taken on each falling edge |
| wr_n | input | 1 | Active-low level write strobe for the input registers |
| upd_n | input | 1 | Active-low level update strobe for the output registers |
| dac_q | output | 32 | Four output registers; channel k is at bits 8k+7:8k |
| ser_out | output | 1 | Oldest shift-register bit, for chaining to the next device |

## Verification
The hardest condition to reach from the ports is the state where the input registers hold values that differ from the output registers. Only there can a check show that a write leaks through without an update. To reach it, the bench writes every vector into its input register and checks all 32 output bits before it pulses the update strobe. The cascade output is tested by shifting a second frame behind a known first frame. The bench compares `ser_out` after each extra falling edge with the matching bit of the first frame. The bench also changes `ser_in` during the high phase of `ser_clk`, to show that those changes are not shifted in.

// File: rtl/quad_dac_loader.sv
module quad_dac_loader #(
  parameter int DW   = 8,
  parameter int AW   = 2,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 ser_clk,
  input  logic                 wr_n,
  input  logic                 upd_n,
  output logic [(DW<<AW)-1:0]  dac_q,
  output logic                 ser_out
);
  localparam int NCH = 1 << AW;
  localparam int FW  = AW + DW;

  logic [SYNC-1:0] din_s, sck_s, wr_s, upd_s;
  logic            sck_d;
  logic [FW-1:0]   sh;
  logic [NCH-1:0][DW-1:0] in_q, dac_r;

  wire din_q    = din_s[SYNC-1];
  wire sck_q    = sck_s[SYNC-1];
  wire wr_q     = wr_s[SYNC-1];
  wire upd_q    = upd_s[SYNC-1];
  wire sck_fall = sck_d & ~sck_q;
  wire [AW-1:0] addr = sh[FW-1 -: AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_s <= '0;
      sck_s <= '0;
      wr_s  <= '0;
      upd_s <= '0;
      sck_d <= 1'b0;
      sh    <= '0;
      in_q  <= '0;
      dac_r <= '0;
    end else begin
      din_s <= {din_s[SYNC-2:0], ser_in};
      sck_s <= {sck_s[SYNC-2:0], ser_clk};
      wr_s  <= {wr_s[SYNC-2:0], wr_n};
      upd_s <= {upd_s[SYNC-2:0], upd_n};
      sck_d <= sck_q;
      if (sck_fall) sh <= {sh[FW-2:0], din_q};
      if (!wr_q) in_q[addr] <= sh[DW-1:0];
      if (!upd_q) dac_r <= in_q;
    end
  end

  assign dac_q   = dac_r;
  assign ser_out = sh[FW-1];
endmodule

module qdl_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fall,
  input logic [AW+DW-1:0]    sh,
  input logic                wr_q,
  input logic                upd_q,
  input logic [(DW<<AW)-1:0] in_q,
  input logic [(DW<<AW)-1:0] dac,
  input logic                sout
);
  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> $stable(dac));
  // R3
  inreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> $stable(in_q));
  // R5
  dac_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> dac == $past(in_q));
  // R6
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sh));
  // R7
  cascade_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> sout == $past(sh[AW+DW-2]));
endmodule

bind quad_dac_loader qdl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall(sck_fall), .sh(sh), .wr_q(wr_q),
  .upd_q(upd_q), .in_q(in_q), .dac(dac_r), .sout(ser_out)
);

// File: tb/sim_quad_dac_loader.sv
module sim_quad_dac_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_in = 1'b1, ser_clk = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [31:0] dac_q;
  logic ser_out;
  int nchk = 0, nfail = 0;
  logic [7:0] imdl [4];
  logic [7:0] dmdl [4];
  logic done = 1'b0;

  always #2 clk = ~clk;

  quad_dac_loader u0 (.clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_clk(ser_clk),
    .wr_n(wr_n), .upd_n(upd_n), .dac_q(dac_q), .ser_out(ser_out));

  localparam logic [9:0] VEC [8] = '{
    {2'b00, 8'hA5}, {2'b01, 8'h3C}, {2'b10, 8'hFF}, {2'b11, 8'h01},
    {2'b10, 8'h80}, {2'b00, 8'h5A}, {2'b11, 8'hC3}, {2'b01, 8'h00}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dmodel();
    return {dmdl[3], dmdl[2], dmdl[1], dmdl[0]};
  endfunction

  task automatic sbit(input logic b, input logic wiggle);
    @(negedge clk) ser_in = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (5) @(negedge clk);
    ser_clk = 1'b1;
    if (wiggle) begin
      repeat (2) @(negedge clk) ser_in = ~ser_in;
      repeat (2) @(negedge clk) ser_in = ~ser_in;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input logic [9:0] f, input logic wiggle);
    for (int i = 9; i >= 0; i--) sbit(f[i], wiggle);
  endtask

  task automatic pulse_wr();
    @(negedge clk) wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_upd();
    @(negedge clk) upd_n = 1'b0;
    repeat (6) @(negedge clk);
    upd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin imdl[i] = 8'h00; dmdl[i] = 8'h00; end
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 dac reset", dac_q, 32'h0);
    check("R9 ser_out reset", {31'b0, ser_out}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 idle after reset", dac_q, 32'h0);

    for (int v = 0; v < 8; v++) begin
      frame(VEC[v], 1'b0);
      pulse_wr();
      imdl[VEC[v][9:8]] = VEC[v][7:0];
      // R4 staged write must not reach the outputs
      check("R4 no update without strobe", dac_q, dmodel());
      pulse_upd();
      for (int c = 0; c < 4; c++) dmdl[c] = imdl[c];
      // R1 R2 R3 R5
      check("R1/R2/R3/R5 vector", dac_q, dmodel());
    end

    // R4 stage all four channels, then one update
    frame({2'b00, 8'h11}, 1'b0); pulse_wr(); imdl[0] = 8'h11;
    frame({2'b01, 8'h22}, 1'b0); pulse_wr(); imdl[1] = 8'h22;
    frame({2'b10, 8'h33}, 1'b0); pulse_wr(); imdl[2] = 8'h33;
    frame({2'b11, 8'h44}, 1'b0); pulse_wr(); imdl[3] = 8'h44;
    check("R4 four staged, outputs held", dac_q, dmodel());
    pulse_upd();
    for (int c = 0; c < 4; c++) dmdl[c] = imdl[c];
    check("R5 simultaneous update", dac_q, 32'h44332211);

    // R6 data wiggle while serial clock high
    frame({2'b10, 8'h96}, 1'b1);
    pulse_wr(); imdl[2] = 8'h96;
    pulse_upd(); dmdl[2] = 8'h96;
    check("R6 high-phase changes ignored", dac_q, dmodel());

    // R7 cascade output
    frame({2'b01, 8'hB4}, 1'b0);
    check("R7 ser_out after frame", {31'b0, ser_out}, {31'b0, 1'b0});
    begin
      logic [9:0] f1;
      f1 = {2'b01, 8'hB4};
      for (int k = 1; k < 10; k++) begin
        sbit(1'b0, 1'b0);
        check("R7 cascade bit", {31'b0, ser_out}, {31'b0, f1[9-k]});
      end
      sbit(1'b1, 1'b0);
      check("R7 next frame head", {31'b0, ser_out}, 32'h0);
    end

    // R8 both strobes low together
    frame({2'b11, 8'h7E}, 1'b0);
    @(negedge clk) begin wr_n = 1'b0; upd_n = 1'b0; end
    repeat (8) @(negedge clk);
    imdl[3] = 8'h7E; dmdl = imdl;
    check("R8 both strobes", dac_q, dmodel());
    @(negedge clk) begin wr_n = 1'b1; upd_n = 1'b1; end
    repeat (6) @(negedge clk);
    check("R8 value held", dac_q, dmodel());

    // R9 reset clears again
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 re-reset", dac_q, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule